// File: doc/BRIEF.md
# Miss and Write Buffer Allocation Front End

This block sits between a cache's lookup logic and two small miss-tracking queues. One queue, the miss queue, holds outstanding cacheable fills and uncached reads. The other, the write buffer, holds write-only requests. Each cycle the block can take one allocation request and one mark-in-service pulse. The request's kind decides which queue it goes to and how its address and size are shaped. Cacheable fills are widened to a whole aligned block. Uncached reads and writes keep their exact address and length.

Every accepted allocation is stamped with a number from one counter shared by both queues, so downstream logic can recover the global arrival order. The block reports to a blocking controller: a per-queue block pulse when an allocation fills a queue, and a per-queue unblock pulse when a service mark takes a queue from full to not full. When the request asks for it, the block also raises a memory-side bus request tagged with the queue's cause. A read port returns any stored entry, and the outcome of each request is reported one cycle after it is presented.

Top module: `missbuf_alloc`

## Requirements
- R1: A request of kind 0 (cacheable fill) goes to the miss queue (queue 0). It is stored and reported with address `alloc_addr & ~(BLK_BYTES-1)` and size `BLK_BYTES`.
- R2: A request of kind 1 (uncached read) goes to the miss queue (queue 0) with its exact address and size.
- R3: A request of kind 2 (write) goes to the write buffer (queue 1) with its exact address and size.
- R4: Every accepted allocation in either queue takes the current value of one shared order counter, which starts at 0 after reset, as its order stamp. The counter then increments by one.
- R5: An allocation that leaves its queue full gives a one-cycle pulse on `block_set[q]` together with `rsp_ok`. Bit 0 is the miss-queue cause and bit 1 is the write-buffer cause.
- R6: `unblock[q]` pulses for one cycle only when a service mark finds queue q full and leaves it not full.
- R7: An accepted allocation with `alloc_bus_req` high gives a one-cycle pulse on `bus_req[q]` for its queue's cause. A rejected one gives no pulse.
- R8: An allocation of kind 3, or one to a queue that is full, is rejected. The block pulses `rsp_err` and changes no entry, no occupancy and no order counter value.
- R9: A service mark frees its entry at the same edge. An allocation in the same cycle is judged on the occupancy from before that free.
- R10: A service mark naming a slot that is empty or beyond the queue's depth is ignored.
- R11: An allocation takes the lowest-numbered free slot of its queue. `q_full[q]` is high exactly when all of that queue's slots are occupied.
- R12: All response, block, unblock and bus-request outputs appear in the cycle after the request. After reset they are all zero, the queues are empty and `q_full` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_kind | input | 2 | 0 fill, 1 uncached read, 2 write, 3 illegal |
| alloc_addr | input | AW | Request address |
| alloc_size | input | SW | Request size in bytes |
| alloc_bus_req | input | 1 | Ask for a memory-side bus request |
| svc_valid | input | 1 | Mark-in-service pulse |
| svc_queue | input | 1 | Queue of the entry put in service (0 miss, 1 write) |
| svc_slot | input | SLW | Slot put in service |
| rd_queue | input | 1 | Read-port queue select |
| rd_slot | input | SLW | Read-port slot select |
| rsp_ok | output | 1 | Allocation accepted (one cycle later) |
| rsp_err | output | 1 | Allocation rejected (one cycle later) |
| rsp_queue | output | 1 | Queue of the accepted entry |
| rsp_slot | output | SLW | Slot of the accepted entry |
| rsp_order | output | OW | Order stamp of the accepted entry |
| rsp_addr | output | AW | Stored address of the accepted entry |
| rsp_size | output | SW | Stored size of the accepted entry |
| block_set | output | 2 | Per-cause block pulse |
| unblock | output | 2 | Per-cause unblock pulse |
| bus_req | output | 2 | Per-cause memory-side bus request pulse |
| q_full | output | 2 | Per-queue full flag |
| rd_valid | output | 1 | Selected entry is occupied |
| rd_addr | output | AW | Selected entry address |
| rd_size | output | SW | Selected entry size |
| rd_order | output | OW | Selected entry order stamp |

## Verification
An allocation and a service mark can land in the same cycle, even on the same queue. The capacity rule decides the outcome: a full queue rejects the allocation while the mark frees a slot and raises an unblock. A queue one short of full accepts the allocation with neither a block nor an unblock. The bench provokes these cases with directed cycles on a write buffer of depth two, and it also reaches them through random mixes of both inputs. A reference model keeps the occupancy from before the free and judges every pulse, every slot and every stamp against it.

// File: rtl/missbuf_pkg.sv
package missbuf_pkg;

   typedef enum logic [1:0] {
      K_FILL   = 2'd0,
      K_UNC_RD = 2'd1,
      K_WRITE  = 2'd2,
      K_BAD    = 2'd3
   } req_kind_e;

   localparam int unsigned CAUSE_MISSQ = 0;
   localparam int unsigned CAUSE_WBUF  = 1;
   localparam int unsigned N_CAUSE     = 2;

   function automatic int unsigned clog2_min1(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/missbuf_shaper.sv
module missbuf_shaper
   import missbuf_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SW        = 8,
   parameter int unsigned BLK_BYTES = 64
) (
   input  logic [1:0]    kind,
   input  logic [AW-1:0] addr_in,
   input  logic [SW-1:0] size_in,
   output logic [AW-1:0] addr_out,
   output logic [SW-1:0] size_out,
   output logic          queue_sel,
   output logic          legal
);
   localparam int unsigned OFFW = $clog2(BLK_BYTES);

   req_kind_e       k;
   logic [AW-1:0]   aligned;

   assign k = req_kind_e'(kind);

   generate
      if (OFFW == 0) begin : g_no_align
         assign aligned = addr_in;
      end else begin : g_align
         assign aligned = {addr_in[AW-1:OFFW], {OFFW{1'b0}}};
      end
   endgenerate

   always_comb begin
      legal     = (k != K_BAD);
      queue_sel = (k == K_WRITE);
      if (k == K_FILL) begin
         addr_out = aligned;
         size_out = SW'(BLK_BYTES);
      end else begin
         addr_out = addr_in;
         size_out = size_in;
      end
   end

endmodule

// File: rtl/missbuf_queue.sv
module missbuf_queue #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned AW    = 32,
   parameter int unsigned SW    = 8,
   parameter int unsigned OW    = 16,
   parameter int unsigned SLW   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ins_en,
   input  logic [AW-1:0]  ins_addr,
   input  logic [SW-1:0]  ins_size,
   input  logic [OW-1:0]  ins_order,
   input  logic           rel_en,
   input  logic [SLW-1:0] rel_slot,
   input  logic [SLW-1:0] rd_slot,
   output logic           full_now,
   output logic           full_next,
   output logic [SLW-1:0] ins_slot,
   output logic           rel_hit,
   output logic           rd_valid,
   output logic [AW-1:0]  rd_addr,
   output logic [SW-1:0]  rd_size,
   output logic [OW-1:0]  rd_order
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [DEPTH-1:0] ent_v;
   logic [AW-1:0]    ent_addr  [DEPTH];
   logic [SW-1:0]    ent_size  [DEPTH];
   logic [OW-1:0]    ent_order [DEPTH];
   logic [CW-1:0]    occ, occ_nx;

   // lowest free slot
   always_comb begin
      ins_slot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!ent_v[i]) ins_slot = SLW'(i);
      end
   end

   always_comb begin
      rel_hit = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rel_en && rel_slot == SLW'(i) && ent_v[i]) rel_hit = 1'b1;
      end
   end

   always_comb begin
      rd_valid = 1'b0;
      rd_addr  = '0;
      rd_size  = '0;
      rd_order = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_slot == SLW'(i)) begin
            rd_valid = ent_v[i];
            rd_addr  = ent_addr[i];
            rd_size  = ent_size[i];
            rd_order = ent_order[i];
         end
      end
   end

   assign occ_nx    = occ + CW'(ins_en) - CW'(rel_hit);
   assign full_now  = (occ == CW'(DEPTH));
   assign full_next = (occ_nx == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ <= '0;
      end else begin
         occ <= occ_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_addr[i]  <= '0;
            ent_size[i]  <= '0;
            ent_order[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ins_en && ins_slot == SLW'(i)) begin
               ent_v[i]     <= 1'b1;
               ent_addr[i]  <= ins_addr;
               ent_size[i]  <= ins_size;
               ent_order[i] <= ins_order;
            end else if (rel_hit && rel_slot == SLW'(i)) begin
               ent_v[i] <= 1'b0;
            end
         end
      end
   end

   // R11: occupancy counter agrees with the valid bits
   p_occ_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      occ == CW'($countones(ent_v)));

   // R8: never inserts into a full queue
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !full_now);

   // R9: a released entry is empty after the edge
   p_rel_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rel_hit |=> !rd_valid || rd_slot != $past(rel_slot));

endmodule

// File: rtl/missbuf_alloc.sv
module missbuf_alloc
   import missbuf_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SW        = 8,
   parameter int unsigned OW        = 16,
   parameter int unsigned BLK_BYTES = 64,
   parameter int unsigned MQ_DEPTH  = 4,
   parameter int unsigned WB_DEPTH  = 2,
   localparam int unsigned MAXD     = (MQ_DEPTH > WB_DEPTH) ? MQ_DEPTH : WB_DEPTH,
   localparam int unsigned SLW      = clog2_min1(MAXD)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc_valid,
   input  logic [1:0]     alloc_kind,
   input  logic [AW-1:0]  alloc_addr,
   input  logic [SW-1:0]  alloc_size,
   input  logic           alloc_bus_req,
   input  logic           svc_valid,
   input  logic           svc_queue,
   input  logic [SLW-1:0] svc_slot,
   input  logic           rd_queue,
   input  logic [SLW-1:0] rd_slot,
   output logic           rsp_ok,
   output logic           rsp_err,
   output logic           rsp_queue,
   output logic [SLW-1:0] rsp_slot,
   output logic [OW-1:0]  rsp_order,
   output logic [AW-1:0]  rsp_addr,
   output logic [SW-1:0]  rsp_size,
   output logic [1:0]     block_set,
   output logic [1:0]     unblock,
   output logic [1:0]     bus_req,
   output logic [1:0]     q_full,
   output logic           rd_valid,
   output logic [AW-1:0]  rd_addr,
   output logic [SW-1:0]  rd_size,
   output logic [OW-1:0]  rd_order
);

   // elaboration checks
   if ((BLK_BYTES == 0) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_chk_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (BLK_BYTES >= (1 << SW)) begin : g_chk_sw
      $error("BLK_BYTES must fit in SW bits");
   end
   if (MQ_DEPTH == 0 || WB_DEPTH == 0) begin : g_chk_depth
      $error("queue depths must be nonzero");
   end

   logic [AW-1:0]  sh_addr;
   logic [SW-1:0]  sh_size;
   logic           sh_q;
   logic           sh_legal;
   logic           accept;
   logic [OW-1:0]  ord_cnt;

   logic           full_now  [N_CAUSE];
   logic           full_next [N_CAUSE];
   logic [SLW-1:0] ins_slot  [N_CAUSE];
   logic           rel_hit   [N_CAUSE];
   logic           ins_en    [N_CAUSE];
   logic           q_rd_v    [N_CAUSE];
   logic [AW-1:0]  q_rd_a    [N_CAUSE];
   logic [SW-1:0]  q_rd_s    [N_CAUSE];
   logic [OW-1:0]  q_rd_o    [N_CAUSE];

   missbuf_shaper #(
      .AW(AW), .SW(SW), .BLK_BYTES(BLK_BYTES)
   ) shaper_i (
      .kind      (alloc_kind),
      .addr_in   (alloc_addr),
      .size_in   (alloc_size),
      .addr_out  (sh_addr),
      .size_out  (sh_size),
      .queue_sel (sh_q),
      .legal     (sh_legal)
   );

   // capacity judged on state before any same-cycle release
   assign accept = alloc_valid && sh_legal && !(sh_q ? full_now[1] : full_now[0]);

   genvar q;
   generate
      for (q = 0; q < N_CAUSE; q++) begin : g_q
         localparam int unsigned D = (q == CAUSE_MISSQ) ? MQ_DEPTH : WB_DEPTH;
         assign ins_en[q] = accept && (sh_q == q[0]);

         missbuf_queue #(
            .DEPTH(D), .AW(AW), .SW(SW), .OW(OW), .SLW(SLW)
         ) queue_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ins_en    (ins_en[q]),
            .ins_addr  (sh_addr),
            .ins_size  (sh_size),
            .ins_order (ord_cnt),
            .rel_en    (svc_valid && (svc_queue == q[0])),
            .rel_slot  (svc_slot),
            .rd_slot   (rd_slot),
            .full_now  (full_now[q]),
            .full_next (full_next[q]),
            .ins_slot  (ins_slot[q]),
            .rel_hit   (rel_hit[q]),
            .rd_valid  (q_rd_v[q]),
            .rd_addr   (q_rd_a[q]),
            .rd_size   (q_rd_s[q]),
            .rd_order  (q_rd_o[q])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               block_set[q] <= 1'b0;
               unblock[q]   <= 1'b0;
               bus_req[q]   <= 1'b0;
            end else begin
               block_set[q] <= ins_en[q] && full_next[q];
               unblock[q]   <= rel_hit[q] && full_now[q] && !full_next[q];
               bus_req[q]   <= ins_en[q] && alloc_bus_req;
            end
         end

         assign q_full[q] = full_now[q];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_cnt   <= '0;
         rsp_ok    <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_queue <= 1'b0;
         rsp_slot  <= '0;
         rsp_order <= '0;
         rsp_addr  <= '0;
         rsp_size  <= '0;
      end else begin
         rsp_ok  <= accept;
         rsp_err <= alloc_valid && !accept;
         if (accept) begin
            ord_cnt   <= ord_cnt + 1'b1;
            rsp_queue <= sh_q;
            rsp_slot  <= sh_q ? ins_slot[1] : ins_slot[0];
            rsp_order <= ord_cnt;
            rsp_addr  <= sh_addr;
            rsp_size  <= sh_size;
         end
      end
   end

   assign rd_valid = rd_queue ? q_rd_v[1] : q_rd_v[0];
   assign rd_addr  = rd_queue ? q_rd_a[1] : q_rd_a[0];
   assign rd_size  = rd_queue ? q_rd_s[1] : q_rd_s[0];
   assign rd_order = rd_queue ? q_rd_o[1] : q_rd_o[0];

   // R4: counter runs one ahead of the last stamp handed out
   p_order_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok |-> ord_cnt == rsp_order + 1'b1);

   // R8: rejection leaves the order counter untouched
   p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $stable(ord_cnt));

   // R8: accept and reject exclusive
   p_ok_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_ok && rsp_err));

   // R5: block pulse only with an accepted allocation into a now-full queue
   p_block_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      block_set[0] |-> rsp_ok && !rsp_queue && q_full[0]);
   p_block_wbuf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      block_set[1] |-> rsp_ok && rsp_queue && q_full[1]);

   // R6: unblock only on a full to not-full transition
   p_unblock_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unblock[0] |-> $past(q_full[0]) && !q_full[0]);
   p_unblock_wbuf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unblock[1] |-> $past(q_full[1]) && !q_full[1]);

   // R7: bus request only with an accepted allocation of that queue
   p_busreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|bus_req) |-> rsp_ok && $onehot0(bus_req) && bus_req[rsp_queue]);

endmodule

// File: tb/missbuf_alloc_tb_top.sv
module missbuf_alloc_tb_top;
   localparam int AW = 32, SW = 8, OW = 16, BLK = 64, SLW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic           alloc_valid = 0, alloc_bus_req = 0, svc_valid = 0, svc_queue = 0, rd_queue = 0;
   logic [1:0]     alloc_kind = 0;
   logic [AW-1:0]  alloc_addr = 0;
   logic [SW-1:0]  alloc_size = 0;
   logic [SLW-1:0] svc_slot = 0, rd_slot = 0;
   logic           rsp_ok, rsp_err, rsp_queue, rd_valid;
   logic [SLW-1:0] rsp_slot;
   logic [OW-1:0]  rsp_order, rd_order;
   logic [AW-1:0]  rsp_addr, rd_addr;
   logic [SW-1:0]  rsp_size, rd_size;
   logic [1:0]     block_set, unblock, bus_req, q_full;

   missbuf_alloc #(.AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK), .MQ_DEPTH(4), .WB_DEPTH(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
      .alloc_addr(alloc_addr), .alloc_size(alloc_size), .alloc_bus_req(alloc_bus_req),
      .svc_valid(svc_valid), .svc_queue(svc_queue), .svc_slot(svc_slot),
      .rd_queue(rd_queue), .rd_slot(rd_slot), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
      .rsp_queue(rsp_queue), .rsp_slot(rsp_slot), .rsp_order(rsp_order),
      .rsp_addr(rsp_addr), .rsp_size(rsp_size), .block_set(block_set), .unblock(unblock),
      .bus_req(bus_req), .q_full(q_full), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_size(rd_size), .rd_order(rd_order));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model
   bit          m_v   [2][4];
   logic [AW-1:0] m_a [2][4];
   logic [SW-1:0] m_s [2][4];
   logic [OW-1:0] m_o [2][4];
   int          m_cnt [2];
   logic [OW-1:0] m_ord;

   function automatic int depth_of(input int q);
      return (q == 0) ? 4 : 2;
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int q = 0; q < 2; q++) begin
         m_cnt[q] = 0;
         for (int i = 0; i < 4; i++) begin
            m_v[q][i] = 0; m_a[q][i] = 0; m_s[q][i] = 0; m_o[q][i] = 0;
         end
      end
      m_ord = 0;
   endtask

   // one cycle: drive at negedge, judge after the next posedge
   task automatic step(input bit av, input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [SW-1:0] s, input bit br,
                       input bit sv, input bit sq, input logic [SLW-1:0] ss);
      int q, slot, cnt_before[2];
      bit legal, acc, svc_eff[2];
      logic [AW-1:0] ea;
      logic [SW-1:0] es;
      logic [1:0] exp_blk, exp_unb, exp_br;
      alloc_valid = av; alloc_kind = k; alloc_addr = a; alloc_size = s;
      alloc_bus_req = br; svc_valid = sv; svc_queue = sq; svc_slot = ss;
      q = (k == 2'd2) ? 1 : 0;
      legal = (k != 2'd3);
      acc = av && legal && (m_cnt[q] < depth_of(q));
      ea = (k == 2'd0) ? (a & ~AW'(BLK - 1)) : a;
      es = (k == 2'd0) ? SW'(BLK) : s;
      slot = 0;
      for (int i = depth_of(q) - 1; i >= 0; i--) if (!m_v[q][i]) slot = i;
      for (int j = 0; j < 2; j++) begin
         cnt_before[j] = m_cnt[j];
         svc_eff[j] = sv && (sq == j[0]) && (int'(ss) < depth_of(j)) && m_v[j][ss];
      end
      // model update: release then insert (different slots)
      for (int j = 0; j < 2; j++) if (svc_eff[j]) begin m_v[j][ss] = 0; m_cnt[j]--; end
      exp_blk = 0; exp_br = 0; exp_unb = 0;
      if (acc) begin
         m_v[q][slot] = 1; m_a[q][slot] = ea; m_s[q][slot] = es; m_o[q][slot] = m_ord;
         m_cnt[q]++;
         exp_blk[q] = (m_cnt[q] == depth_of(q));
         exp_br[q] = br;
      end
      for (int j = 0; j < 2; j++)
         exp_unb[j] = svc_eff[j] && cnt_before[j] == depth_of(j) && m_cnt[j] < depth_of(j);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "rsp_ok", rsp_ok, acc);
      chk("R8", "rsp_err", rsp_err, av && !acc);
      if (acc) begin
         chk("R1/R2/R3", "rsp_queue", rsp_queue, q);
         chk(k == 0 ? "R1" : (k == 1 ? "R2" : "R3"), "rsp_addr", rsp_addr, ea);
         chk(k == 0 ? "R1" : (k == 1 ? "R2" : "R3"), "rsp_size", rsp_size, es);
         chk("R4", "rsp_order", rsp_order, m_ord);
         chk("R11", "rsp_slot", rsp_slot, slot);
         m_ord = m_ord + 1'b1;
      end
      chk("R5", "block_set", block_set, exp_blk);
      chk("R6", "unblock", unblock, exp_unb);
      chk("R7", "bus_req", bus_req, exp_br);
      chk("R11", "q_full", q_full, {m_cnt[1] == 2, m_cnt[0] == 4});
      alloc_valid = 0; svc_valid = 0;
   endtask

   // inspect one slot through the read port (R9, R10, R8 state)
   task automatic peek(input bit q, input int i, input string req);
      rd_queue = q; rd_slot = SLW'(i);
      #1;
      chk(req, "rd_valid", rd_valid, (i < depth_of(q)) ? m_v[q][i] : 0);
      if (i < depth_of(q) && m_v[q][i]) begin
         chk(req, "rd_addr", rd_addr, m_a[q][i]);
         chk(req, "rd_size", rd_size, m_s[q][i]);
         chk(req, "rd_order", rd_order, m_o[q][i]);
      end
   endtask

   task automatic peek_all(input string req);
      for (int q = 0; q < 2; q++)
         for (int i = 0; i < 4; i++) peek(q[0], i, req);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         finished = 1;
         report();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      chk("R12", "rsp_ok", rsp_ok, 0);
      chk("R12", "rsp_err", rsp_err, 0);
      chk("R12", "block_set", block_set, 0);
      chk("R12", "unblock", unblock, 0);
      chk("R12", "bus_req", bus_req, 0);
      chk("R12", "q_full", q_full, 0);
      peek_all("R12");

      // R1 unaligned cacheable fill with bus request
      step(1, 2'd0, 32'h0000_1234, 8'd4, 1, 0, 0, 0);
      // R2 uncached read keeps exact address
      step(1, 2'd1, 32'h0000_5677, 8'd3, 0, 0, 0, 0);
      // R3 writes fill the write buffer; second one blocks (R5)
      step(1, 2'd2, 32'h0000_9001, 8'd2, 1, 0, 0, 0);
      step(1, 2'd2, 32'h0000_9005, 8'd1, 0, 0, 0, 0);
      // R8 write while full is rejected
      step(1, 2'd2, 32'h0000_aaaa, 8'd8, 1, 0, 0, 0);
      peek_all("R8");
      // R9 simultaneous write and release of a full write buffer: rejected, unblock (R6)
      step(1, 2'd2, 32'h0000_bbbb, 8'd8, 1, 1, 1, 2'd0);
      peek_all("R9");
      // R9 one short of full: alloc and release together, no block, no unblock
      step(1, 2'd2, 32'h0000_cccc, 8'd6, 0, 1, 1, 2'd1);
      // R10 release of an out-of-range and an empty slot is ignored
      step(0, 2'd0, 0, 0, 0, 1, 1, 2'd3);
      step(0, 2'd0, 0, 0, 0, 1, 0, 2'd3);
      peek_all("R10");
      // R8 illegal kind
      step(1, 2'd3, 32'h0000_dddd, 8'd1, 1, 0, 0, 0);
      peek_all("R8");
      // fill miss queue to block (R5), then free from full (R6)
      step(1, 2'd0, 32'h0001_0040, 8'd1, 0, 0, 0, 0);
      step(1, 2'd1, 32'h0001_0081, 8'd2, 0, 0, 0, 0);
      step(1, 2'd0, 32'h0001_00ff, 8'd2, 1, 1, 0, 2'd2);
      step(0, 2'd0, 0, 0, 0, 1, 0, 2'd1);
      peek_all("R11");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         bit av, br, sv, sq;
         logic [1:0] k;
         logic [SLW-1:0] ss;
         av = ($urandom % 10) < 6;
         k  = (($urandom % 16) == 0) ? 2'd3 : 2'($urandom % 3);
         br = $urandom % 2;
         sv = ($urandom % 10) < 4;
         sq = $urandom % 2;
         ss = SLW'($urandom % 4);
         step(av, k, $urandom, SW'($urandom), br, sv, sq, ss);
         peek($urandom % 2, $urandom % 4, "R9");
      end

      if (!finished) begin
         finished = 1;
         report();
      end
   end

endmodule